// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Gate

This block gathers the per-channel outcome events of a multi-channel DMA engine into one 32-bit status word and turns that word into a single interrupt line. Each channel can report three kinds of outcome: an error, an abort and a terminal count (normal completion). Each kind has its own 8-bit lane of the status word, and the channel number is the bit offset inside the lane. A one-cycle pulse on an event input sets the matching flag. The flag then stays set until software clears it by writing a one to that bit position.

Each channel also supplies a 3-bit mask field. A set mask bit keeps the matching flag from raising the interrupt. The flag itself still latches and can still be read. The interrupt line is high whenever at least one flag is set and its mask bit is clear. A per-channel running indication is high while none of the channel's three flags is set. Several flags of one channel can be set at the same time, and one write can clear all three.

The register port is plain, with no flow control. A write is accepted in every cycle in which `reg_wr_i` is high. No valid/ready handshake is used and there is no back-pressure: events are never stalled, and the status word is always visible on `reg_rdata_o`.

Top module: `dma_irq_status`

## Requirements
- R1: A one-cycle pulse on an event input sets the matching status flag. The flag is visible on `reg_rdata_o` from the cycle after the pulse and stays set while no clear is written to it.
- R2: Error flags sit in bits 0 to 7, abort flags in bits 8 to 15 and terminal-count flags in bits 16 to 23. Channel n uses bit offset n inside each lane.
- R3: A write with a 1 in a flag's bit position clears that flag from the next cycle on. A 0 in the write data leaves the flag unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag is set afterwards.
- R5: Bits 24 to 31 of `reg_rdata_o` always read 0, and writes to them have no effect on any bit of the status word.
- R6: The mask field of channel n is `irq_mask_i[3n+2:3n]`: bit 3n masks error, bit 3n+1 masks abort and bit 3n+2 masks terminal count. A set mask bit keeps its flag from driving `irq_o`, although the flag still latches.
- R7: `irq_o` is high exactly when some status flag is set and its mask bit is clear. It follows the mask inputs in the same cycle, with no register on the way.
- R8: `ch_running_o[n]` is high exactly when none of channel n's three flags is set. Two or all three flags of one channel can be set at the same time.
- R9: A single write with bits n, 8+n and 16+n set clears all three flags of channel n and leaves the flags of other channels unchanged.
- R10: After reset the status word is 0, `irq_o` is low and every `ch_running_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_evt_i | input | NCH | Per-channel error event pulses |
| abt_evt_i | input | NCH | Per-channel abort event pulses |
| done_evt_i | input | NCH | Per-channel terminal-count event pulses |
| irq_mask_i | input | 3*NCH | Per-channel mask fields (bit set means interrupt off) |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 32 | Write data (a 1 clears the flag at that position) |
| reg_rdata_o | output | 32 | Current status word |
| irq_o | output | 1 | Combined interrupt |
| ch_running_o | output | NCH | Channel has no flag set |

## Verification
Two functions can land on the same flag in the same cycle: a new event pulse and a software write that clears that bit. The bench provokes this by driving a pulse on an error input together with a write of a one to the same position. It expects the flag to read as set after the edge. A second case drives a pulse on one channel during a write that clears a different flag. The bench then checks that the set and the clear each take effect on their own bit only.

// File: rtl/dma_irqstat_pkg.sv
package dma_irqstat_pkg;
  localparam int LANE_W  = 8;
  localparam int NUM_CLS = 3;
  localparam int WORD_W  = 4 * LANE_W;

  typedef enum logic [1:0] {
    CLS_ERR  = 2'd0,
    CLS_ABT  = 2'd1,
    CLS_DONE = 2'd2
  } evt_class_e;

  function automatic int lane_base(input int cls);
    return cls * LANE_W;
  endfunction
endpackage

// File: rtl/dma_irqstat_lane.sv
module dma_irqstat_lane #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flags_o
);
  logic [NCH-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;

  // R1
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R4
  set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i)) |=> ((flags_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  // R3
  zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));
endmodule

// File: rtl/dma_irqstat_gate.sv
module dma_irqstat_gate #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   err_f_i,
  input  logic [NCH-1:0]   abt_f_i,
  input  logic [NCH-1:0]   done_f_i,
  input  logic [3*NCH-1:0] mask_i,
  output logic             irq_o,
  output logic [NCH-1:0]   running_o
);
  localparam int MW = 3 * NCH;

  logic [NCH-1:0] m_err, m_abt, m_done;
  logic [NCH-1:0] live;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign m_err[n]     = mask_i[3*n];
    assign m_abt[n]     = mask_i[3*n+1];
    assign m_done[n]    = mask_i[3*n+2];
    assign live[n]      = (err_f_i[n] & ~m_err[n]) | (abt_f_i[n] & ~m_abt[n]) |
                          (done_f_i[n] & ~m_done[n]);
    assign running_o[n] = ~(err_f_i[n] | abt_f_i[n] | done_f_i[n]);
  end

  assign irq_o = |live;

  // R6
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == {MW{1'b1}}) |-> !irq_o);

  // R7
  unmasked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_f_i & ~m_err)) |-> irq_o);

  // R8
  running_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o == {NCH{1'b1}}) |-> !irq_o);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irqstat_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   err_evt_i,
  input  logic [NCH-1:0]   abt_evt_i,
  input  logic [NCH-1:0]   done_evt_i,
  input  logic [3*NCH-1:0] irq_mask_i,
  input  logic             reg_wr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             irq_o,
  output logic [NCH-1:0]   ch_running_o
);
  logic [NCH-1:0] evt_v   [NUM_CLS];
  logic [NCH-1:0] flags_v [NUM_CLS];
  logic [WORD_W-1:0] word;

  assign evt_v[CLS_ERR]  = err_evt_i;
  assign evt_v[CLS_ABT]  = abt_evt_i;
  assign evt_v[CLS_DONE] = done_evt_i;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_lane
    logic [NCH-1:0] clr;
    assign clr = reg_wr_i ? reg_wdata_i[lane_base(c) +: NCH] : '0;
    dma_irqstat_lane #(.NCH(NCH)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (evt_v[c]),
      .clr_i   (clr),
      .flags_o (flags_v[c])
    );
  end

  always_comb begin
    word = '0;
    for (int c = 0; c < NUM_CLS; c++) word[lane_base(c) +: NCH] = flags_v[c];
  end

  assign reg_rdata_o = word;

  dma_irqstat_gate #(.NCH(NCH)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_f_i   (flags_v[CLS_ERR]),
    .abt_f_i   (flags_v[CLS_ABT]),
    .done_f_i  (flags_v[CLS_DONE]),
    .mask_i    (irq_mask_i),
    .irq_o     (irq_o),
    .running_o (ch_running_o)
  );

  // R5
  hi_lane_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_wdata_i[31:24] != 8'h00) |=> (reg_rdata_o[31:24] == 8'h00));

  // R9
  chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_wdata_i[0] && reg_wdata_i[8] && reg_wdata_i[16] &&
     !err_evt_i[0] && !abt_evt_i[0] && !done_evt_i[0]) |=> ch_running_o[0]);
endmodule

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;
  localparam int NCH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   err_evt = '0, abt_evt = '0, done_evt = '0;
  logic [3*NCH-1:0] mask = '0;
  logic             wr = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq;
  logic [NCH-1:0]   running;

  int total = 0;
  int bad = 0;

  logic [31:0]    q_stat [$];
  logic           q_irq  [$];
  logic [NCH-1:0] q_run  [$];
  string          q_tag  [$];

  logic [31:0] exp_stat = '0;

  always #10 clk = ~clk;

  dma_irq_status #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt), .abt_evt_i(abt_evt),
    .done_evt_i(done_evt), .irq_mask_i(mask), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .ch_running_o(running)
  );

  function automatic logic model_irq(input logic [31:0] s, input logic [3*NCH-1:0] m);
    logic r = 1'b0;
    for (int n = 0; n < NCH; n++) begin
      r |= s[n] & ~m[3*n];
      r |= s[8+n] & ~m[3*n+1];
      r |= s[16+n] & ~m[3*n+2];
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] model_run(input logic [31:0] s);
    logic [NCH-1:0] r;
    for (int n = 0; n < NCH; n++) r[n] = ~(s[n] | s[8+n] | s[16+n]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] es, input logic ei,
                       input logic [NCH-1:0] er);
    total++;
    if (rdata !== es || irq !== ei || running !== er) begin
      bad++;
      $display("FAIL %s: status=%h irq=%b run=%b expected status=%h irq=%b run=%b",
               tag, rdata, irq, running, es, ei, er);
    end
  endtask

  task automatic step(input string tag, input logic [NCH-1:0] e, input logic [NCH-1:0] a,
                      input logic [NCH-1:0] d, input logic w, input logic [31:0] wd,
                      input logic [3*NCH-1:0] m);
    logic [31:0] clr;
    @(negedge clk);
    err_evt = e; abt_evt = a; done_evt = d; wr = w; wdata = wd; mask = m;
    clr = w ? {8'h00, wd[23:0]} : 32'h0;
    exp_stat = (exp_stat & ~clr) | {8'h00, d, a, e};
    q_stat.push_back(exp_stat);
    q_irq.push_back(model_irq(exp_stat, m));
    q_run.push_back(model_run(exp_stat));
    q_tag.push_back(tag);
  endtask

  task automatic idle(input logic [3*NCH-1:0] m);
    step("idle", '0, '0, '0, 1'b0, 32'h0, m);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #4;
      if (q_stat.size() != 0)
        check(q_tag.pop_front(), q_stat.pop_front(), q_irq.pop_front(), q_run.pop_front());
    end
  end

  initial begin : watchdog
    #(20 * 5000);
    bad++;
    $display("FAIL watchdog: run not finished, expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #4;
    check("R10 reset", 32'h0, 1'b0, '1);
    @(negedge clk);
    rst_n = 1'b1;

    step("R1 R2 err ch3", 8'h08, '0, '0, 1'b0, 32'h0, '0);
    idle('0);
    step("R2 abort ch0 done ch7", '0, 8'h01, 8'h80, 1'b0, 32'h0, '0);
    step("R3 zero write keeps", '0, '0, '0, 1'b1, 32'h0, '0);
    step("R3 clear bit3", '0, '0, '0, 1'b1, 32'h0000_0008, '0);
    step("R4 set beats clear ch5", 8'h20, '0, '0, 1'b1, 32'h0000_0020, '0);
    step("R3 R4 set ch1 clear bit8", 8'h02, '0, '0, 1'b1, 32'h0000_0100, '0);
    step("R5 high byte write", '0, '0, '0, 1'b1, 32'hFF00_0000, '0);
    step("R6 all masked", '0, '0, '0, 1'b0, 32'h0, '1);
    step("R7 unmask follows", '0, '0, '0, 1'b0, 32'h0, '0);
    step("R3 clear all", '0, '0, '0, 1'b1, 32'h00FF_FFFF, '0);
    step("R6 masked err ch5 latches", 8'h20, '0, '0, 1'b0, 32'h0, 24'h00_8000);
    step("R7 unmask err ch5", '0, '0, '0, 1'b0, 32'h0, 24'h00_0000);
    step("R6 mask abort ch5 only", '0, '0, '0, 1'b0, 32'h0, 24'h01_0000);
    step("R8 three flags ch2", 8'h04, 8'h04, 8'h04, 1'b0, 32'h0, '0);
    step("R8 ch6 done only", '0, '0, 8'h40, 1'b0, 32'h0, '0);
    step("R9 clear ch2 all lanes", '0, '0, '0, 1'b1, 32'h0004_0404, '0);
    step("R9 clear ch5 ch6", '0, '0, '0, 1'b1, 32'h0060_6060, '0);
    step("R10 back to empty", '0, '0, '0, 1'b0, 32'h0, '0);
    idle('0);
    idle('0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule